// File: doc/BRIEF.md
# DMA Control and Interrupt Register File

This block is the word-addressed register file that sits in front of a descriptor-ring DMA engine. Software reaches it through a simple request bus whose byte address is shifted right by two to form a word index. It holds the bus-mode word, the transmit and receive ring base addresses, the current descriptor pointers, the control word, the status word and the interrupt enable mask. A write to the transmit poll index issues a one-cycle start pulse to the transmit engine, and a level interrupt is raised while any status bit is also enabled.

The transmit and receive engines feed the block through a status-set strobe vector and through pointer-load ports that advance the current descriptor pointers. The status word is write-one-to-clear from the bus. Engine sets are merged in the same cycle as a bus clear, and a set wins over a clear of the same bit. Word indices below the register-file depth that are not DMA registers act as plain storage, and two of them (the station address words) reset to a parameter value.

The bus side is a two-state machine. In ST_IDLE the block answers nothing. A read request moves it to ST_RESP (transition IDLE_TO_RESP). In ST_RESP the read data is valid for one cycle. A further read request keeps it there (transition RESP_HOLD), and anything else returns it to ST_IDLE (transition RESP_TO_IDLE). Writes take effect at the edge that samples the request, in either state.

Top module: `dma_csr_top`

## Requirements
- R1: A read request sampled at a clock edge returns its data on `bus_rdata_o` with `bus_rvalid_o` high during the following cycle. `bus_rvalid_o` is never high without a read in the cycle before.
- R2: Writing the status index (0x3C5) clears each status bit that is 1 in the written value and keeps every other bit.
- R3: Writing the transmit base index (0x3C4) or the receive base index (0x3C3) stores the value in that base register and also in the matching current pointer (transmit 0x3D2, receive 0x3D3).
- R4: Bits of `stat_set_i` that are high at a clock edge are set in the status word. When the same bit is set by an engine and cleared by the bus in one cycle, it ends up set.
- R5: A write to the transmit poll index (0x3C1) makes `tx_poll_o` high for exactly the one cycle that follows. The index stores nothing and reads as zero.
- R6: `irq_o` is high exactly when (status AND interrupt enable at 0x3C7) is non-zero. It follows each bus write or status set in the cycle after the edge.
- R7: Writing the bus-mode index (0x3C0) stores the value with bit 0 forced to 0.
- R8: Word index 8 always reads 0x1012, whatever was written to it.
- R9: Word indices at or above 0x400 read as zero. Writes to them change no register, including the one at the same index modulo 0x400.
- R10: `tx_cur_ld_i` / `rx_cur_ld_i` load the matching current pointer from the engine value. A bus write to the matching base or current index in the same cycle takes priority.
- R11: After reset, index 0x10 holds bytes 5 and 4 of `STATION_ADDR` in its low half, and index 0x11 holds bytes 3 to 0. Byte 0 is bits 7:0 of the parameter.
- R12: Every other index below 0x400, including 0x3C2, 0x3C6 and 0x3C7, reads back the last value written. The control word is also driven on `dma_ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, word index is bits ADDR_W-1:2 |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid |
| stat_set_i | input | DATA_W | Status bits to set this cycle |
| tx_cur_ld_i | input | 1 | Load transmit current pointer from engine |
| tx_cur_val_i | input | DATA_W | Engine value for transmit current pointer |
| rx_cur_ld_i | input | 1 | Load receive current pointer from engine |
| rx_cur_val_i | input | DATA_W | Engine value for receive current pointer |
| tx_cur_o | output | DATA_W | Transmit current descriptor pointer |
| rx_cur_o | output | DATA_W | Receive current descriptor pointer |
| bus_mode_o | output | DATA_W | Bus-mode word |
| dma_ctrl_o | output | DATA_W | Control word |
| tx_poll_o | output | 1 | One-cycle transmit start pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 13-bit byte address, 32-bit data and a 1024-word file. The address port therefore spans twice the implemented index range. A full write sweep followed by a full read sweep covers every index, both the aliasing upper half and the lower half, and checks the W1C, forced-bit, constant and write-only rules where they occur. Directed sequences then cover the same-cycle corners: a set colliding with a clear, a base write colliding with an engine pointer load, and the enable/status combinations behind the interrupt.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam int unsigned IX_VERSION = 32'h008;
    localparam int unsigned IX_MAC_HI  = 32'h010;
    localparam int unsigned IX_MAC_LO  = 32'h011;
    localparam int unsigned IX_BUSMODE = 32'h3C0;
    localparam int unsigned IX_TXPOLL  = 32'h3C1;
    localparam int unsigned IX_RXBASE  = 32'h3C3;
    localparam int unsigned IX_TXBASE  = 32'h3C4;
    localparam int unsigned IX_STATUS  = 32'h3C5;
    localparam int unsigned IX_CONTROL = 32'h3C6;
    localparam int unsigned IX_INTEN   = 32'h3C7;
    localparam int unsigned IX_TXCUR   = 32'h3D2;
    localparam int unsigned IX_RXCUR   = 32'h3D3;

    localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

    localparam int unsigned CH_TX = 0;
    localparam int unsigned CH_RX = 1;

endpackage

// File: rtl/dma_csr_bus_fsm.sv
module dma_csr_bus_fsm
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic        wr_stb_o,
    output logic        rd_stb_o,
    output logic [31:0] word_ix_o,
    output logic        rvalid_o
);

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i && !we_i) state_d = ST_RESP;
            ST_RESP: if (!(req_i && !we_i)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_stb_o  = req_i && we_i;
        rd_stb_o  = req_i && !we_i;
        word_ix_o = 32'(addr_i[ADDR_W-1:2]);
        rvalid_o  = (state_q == ST_RESP);
    end

    // R1: valid read data only follows a read request
    assert_rvalid_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(req_i && !we_i));

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] clr_val_i,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] clr_mask;

    assign clr_mask = clr_we_i ? clr_val_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_i;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & enable_i);

    // R4: every strobed bit is present in the next cycle
    assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R2: no bit appears without a set strobe
    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/dma_csr_ring_ptr.sv
module dma_csr_ring_ptr #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we_i,
    input  logic              cur_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              eng_ld_i,
    input  logic [DATA_W-1:0] eng_val_i,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] cur_o
);

    logic [DATA_W-1:0] base_q, cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (base_we_i) begin
            base_q <= wdata_i;
            cur_q  <= wdata_i;
        end else if (cur_we_i) begin
            cur_q  <= wdata_i;
        end else if (eng_ld_i) begin
            cur_q  <= eng_val_i;
        end
    end

    assign base_o = base_q;
    assign cur_o  = cur_q;

    // R3: a base write leaves the current pointer equal to the new base
    assert_base_loads_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_i |=> (cur_q == base_q));

    // R10: an engine load alone moves the pointer to the engine value
    assert_engine_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ld_i && !base_we_i && !cur_we_i) |=> (cur_q == $past(eng_val_i)));

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_WORDS    = 1024,
    parameter logic [47:0] STATION_ADDR = 48'h5A4B_3C2D_1E0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic [DATA_W-1:0] stat_set_i,
    input  logic              tx_cur_ld_i,
    input  logic [DATA_W-1:0] tx_cur_val_i,
    input  logic              rx_cur_ld_i,
    input  logic [DATA_W-1:0] rx_cur_val_i,
    output logic [DATA_W-1:0] tx_cur_o,
    output logic [DATA_W-1:0] rx_cur_o,
    output logic [DATA_W-1:0] bus_mode_o,
    output logic [DATA_W-1:0] dma_ctrl_o,
    output logic              tx_poll_o,
    output logic              irq_o
);

    localparam int unsigned IX_W   = $clog2(NUM_WORDS);
    localparam int unsigned NUM_CH = 2;

    logic        wr_stb, rd_stb;
    logic [31:0] word_ix;
    logic        in_range, is_dma;

    dma_csr_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wr_stb_o  (wr_stb),
        .rd_stb_o  (rd_stb),
        .word_ix_o (word_ix),
        .rvalid_o  (bus_rvalid_o)
    );

    assign in_range = (word_ix < NUM_WORDS);
    assign is_dma   = (word_ix == IX_BUSMODE) || (word_ix == IX_TXPOLL) ||
                      (word_ix == IX_RXBASE)  || (word_ix == IX_TXBASE) ||
                      (word_ix == IX_STATUS)  || (word_ix == IX_CONTROL) ||
                      (word_ix == IX_INTEN)   || (word_ix == IX_TXCUR) ||
                      (word_ix == IX_RXCUR);

    // dedicated DMA words
    logic [DATA_W-1:0] busmode_q, control_q, inten_q, status;
    logic              poll_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busmode_q <= '0;
            control_q <= '0;
            inten_q   <= '0;
            poll_q    <= 1'b0;
        end else begin
            poll_q <= wr_stb && (word_ix == IX_TXPOLL);
            if (wr_stb && word_ix == IX_BUSMODE) busmode_q <= bus_wdata_i & ~DATA_W'(1);
            if (wr_stb && word_ix == IX_CONTROL) control_q <= bus_wdata_i;
            if (wr_stb && word_ix == IX_INTEN)   inten_q   <= bus_wdata_i;
        end
    end

    dma_csr_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we_i  (wr_stb && (word_ix == IX_STATUS)),
        .clr_val_i (bus_wdata_i),
        .set_i     (stat_set_i),
        .enable_i  (inten_q),
        .status_o  (status),
        .irq_o     (irq_o)
    );

    // ring pointers, one instance per channel
    logic [NUM_CH-1:0] base_we, cur_we, eng_ld;
    logic [DATA_W-1:0] eng_val [NUM_CH];
    logic [DATA_W-1:0] base_q  [NUM_CH];
    logic [DATA_W-1:0] cur_q   [NUM_CH];

    assign base_we[CH_TX] = wr_stb && (word_ix == IX_TXBASE);
    assign base_we[CH_RX] = wr_stb && (word_ix == IX_RXBASE);
    assign cur_we[CH_TX]  = wr_stb && (word_ix == IX_TXCUR);
    assign cur_we[CH_RX]  = wr_stb && (word_ix == IX_RXCUR);
    assign eng_ld[CH_TX]  = tx_cur_ld_i;
    assign eng_ld[CH_RX]  = rx_cur_ld_i;
    assign eng_val[CH_TX] = tx_cur_val_i;
    assign eng_val[CH_RX] = rx_cur_val_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ring
        dma_csr_ring_ptr #(.DATA_W(DATA_W)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_we_i (base_we[c]),
            .cur_we_i  (cur_we[c]),
            .wdata_i   (bus_wdata_i),
            .eng_ld_i  (eng_ld[c]),
            .eng_val_i (eng_val[c]),
            .base_o    (base_q[c]),
            .cur_o     (cur_q[c])
        );
    end

    // plain storage for every other index
    logic [DATA_W-1:0] mem_q [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (i == IX_MAC_HI)      mem_q[i] <= DATA_W'(STATION_ADDR[47:32]);
                else if (i == IX_MAC_LO) mem_q[i] <= DATA_W'(STATION_ADDR[31:0]);
                else                     mem_q[i] <= '0;
            end
        end else if (wr_stb && in_range && !is_dma) begin
            mem_q[word_ix[IX_W-1:0]] <= bus_wdata_i;
        end
    end

    // read path
    logic [DATA_W-1:0] rd_mux, rdata_q;

    always_comb begin
        rd_mux = '0;
        if (!in_range)                  rd_mux = '0;
        else if (word_ix == IX_VERSION) rd_mux = DATA_W'(VERSION_WORD);
        else if (word_ix == IX_BUSMODE) rd_mux = busmode_q;
        else if (word_ix == IX_TXPOLL)  rd_mux = '0;
        else if (word_ix == IX_RXBASE)  rd_mux = base_q[CH_RX];
        else if (word_ix == IX_TXBASE)  rd_mux = base_q[CH_TX];
        else if (word_ix == IX_STATUS)  rd_mux = status;
        else if (word_ix == IX_CONTROL) rd_mux = control_q;
        else if (word_ix == IX_INTEN)   rd_mux = inten_q;
        else if (word_ix == IX_TXCUR)   rd_mux = cur_q[CH_TX];
        else if (word_ix == IX_RXCUR)   rd_mux = cur_q[CH_RX];
        else                            rd_mux = mem_q[word_ix[IX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;
    assign tx_cur_o    = cur_q[CH_TX];
    assign rx_cur_o    = cur_q[CH_RX];
    assign bus_mode_o  = busmode_q;
    assign dma_ctrl_o  = control_q;
    assign tx_poll_o   = poll_q;

    // R5: a start pulse only follows a bus write
    assert_poll_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_o |-> $past(bus_req_i && bus_we_i));

    // R6: no interrupt while every enable bit is clear
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (inten_q != '0));

    // R7: the forced bit of the bus-mode word never reads as one
    assert_busmode_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode_o[0]);

endmodule

// File: tb/dma_csr_top_tb.sv
module dma_csr_top_tb;

    localparam int unsigned ADDR_W = 13;
    localparam int unsigned DW     = 32;
    localparam logic [47:0] MACV   = 48'h5A4B_3C2D_1E0F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic [DW-1:0] stat_set = '0;
    logic          tx_ld = 1'b0, rx_ld = 1'b0;
    logic [DW-1:0] tx_val = '0, rx_val = '0;
    logic [DW-1:0] tx_cur, rx_cur, bus_mode, dma_ctrl;
    logic          tx_poll, irq;

    int checks = 0;
    int errors = 0;
    int poll_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma_csr_top #(.ADDR_W(ADDR_W), .DATA_W(DW), .NUM_WORDS(1024), .STATION_ADDR(MACV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .stat_set_i(stat_set),
        .tx_cur_ld_i(tx_ld), .tx_cur_val_i(tx_val),
        .rx_cur_ld_i(rx_ld), .rx_cur_val_i(rx_val),
        .tx_cur_o(tx_cur), .rx_cur_o(rx_cur), .bus_mode_o(bus_mode),
        .dma_ctrl_o(dma_ctrl), .tx_poll_o(tx_poll), .irq_o(irq)
    );

    always @(negedge clk) if (rst_n && tx_poll) poll_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input int ix, input logic [DW-1:0] val);
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(ix << 2); bus_wdata = val;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int ix, output logic [DW-1:0] val);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(ix << 2);
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0;
        val = bus_rdata;
        check("R1 rvalid", DW'(bus_rvalid), 32'd1);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {16'(i) ^ 16'hC0DE, 16'(i)};
    endfunction

    function automatic logic [DW-1:0] sweep_exp(input int i);
        if (i >= 1024)       return '0;
        if (i == 8)          return 32'h0000_1012;
        if (i == 'h3C0)      return pat(i) & ~32'd1;
        if (i == 'h3C1)      return '0;
        if (i == 'h3C5)      return '0;
        return pat(i);
    endfunction

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R6 irq after reset", DW'(irq), 32'd0);
        check("R5 poll after reset", DW'(tx_poll), 32'd0);
        check("R1 rvalid idle", DW'(bus_rvalid), 32'd0);
        bus_read('h10, rd); check("R11 station hi", rd, 32'h0000_5A4B);
        bus_read('h11, rd); check("R11 station lo", rd, 32'h3C2D_1E0F);
        bus_read('h3C5, rd); check("R2 status reset", rd, 32'd0);
        bus_read(8, rd); check("R8 version", rd, 32'h0000_1012);
        @(negedge clk);
        check("R1 rvalid drops", DW'(bus_rvalid), 32'd0);

        // full write sweep then full read sweep (R9, R12, R7, R8, R5)
        for (int i = 0; i < 2048; i++) bus_write(i, pat(i));
        @(negedge clk);
        check("R5 one poll pulse", DW'(poll_cnt), 32'd1);
        check("R6 irq no status", DW'(irq), 32'd0);
        check("R12 control port", dma_ctrl, pat('h3C6));
        check("R7 bus mode port", bus_mode, pat('h3C0) & ~32'd1);
        for (int i = 0; i < 2048; i++) begin
            bus_read(i, rd);
            if (i >= 1024) check("R9 upper index", rd, sweep_exp(i));
            else if (i == 8) check("R8 version after write", rd, sweep_exp(i));
            else if (i == 'h3C1) check("R5 poll reads zero", rd, sweep_exp(i));
            else if (i == 'h3C0) check("R7 bus mode", rd, sweep_exp(i));
            else check("R12 storage", rd, sweep_exp(i));
        end

        // status set and W1C
        bus_write('h3C7, 32'd0);
        stat_set = 32'h0000_00F0; @(negedge clk); stat_set = '0;
        bus_read('h3C5, rd); check("R4 set strobe", rd, 32'h0000_00F0);
        bus_write('h3C5, 32'h0000_0030);
        bus_read('h3C5, rd); check("R2 partial clear", rd, 32'h0000_00C0);
        stat_set = 32'h0000_0041;
        bus_write('h3C5, 32'h0000_00C0);
        stat_set = '0;
        bus_read('h3C5, rd); check("R4 set wins over clear", rd, 32'h0000_0041);

        // interrupt
        check("R6 irq masked", DW'(irq), 32'd0);
        bus_write('h3C7, 32'h0000_0100);
        check("R6 irq other enable", DW'(irq), 32'd0);
        bus_write('h3C7, 32'h0000_0001);
        check("R6 irq raised", DW'(irq), 32'd1);
        bus_write('h3C5, 32'h0000_0001);
        check("R6 irq after clear", DW'(irq), 32'd0);
        stat_set = 32'h0000_0001; @(negedge clk); stat_set = '0;
        check("R6 irq after set", DW'(irq), 32'd1);
        bus_write('h3C5, 32'hFFFF_FFFF);
        check("R6 irq after full clear", DW'(irq), 32'd0);

        // ring bases
        bus_write('h3C4, 32'h8000_1000);
        check("R3 tx cur port", tx_cur, 32'h8000_1000);
        bus_read('h3D2, rd); check("R3 tx cur read", rd, 32'h8000_1000);
        bus_read('h3C4, rd); check("R3 tx base read", rd, 32'h8000_1000);
        bus_write('h3C3, 32'h9000_2000);
        bus_read('h3D3, rd); check("R3 rx cur read", rd, 32'h9000_2000);

        // engine loads
        tx_ld = 1'b1; tx_val = 32'h8000_1040; @(negedge clk); tx_ld = 1'b0;
        bus_read('h3D2, rd); check("R10 engine load", rd, 32'h8000_1040);
        bus_read('h3C4, rd); check("R10 base untouched", rd, 32'h8000_1000);
        rx_ld = 1'b1; rx_val = 32'h9000_2040;
        bus_write('h3C3, 32'h9000_3000);
        rx_ld = 1'b0;
        check("R10 bus wins", rx_cur, 32'h9000_3000);

        // bus mode forced bit
        bus_write('h3C0, 32'hFFFF_FFFF);
        bus_read('h3C0, rd); check("R7 bit0 forced", rd, 32'hFFFF_FFFE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule